// File: doc/BRIEF.md
# Display Controller Command Decoder

This block sits behind a serial-slave byte receiver in a small display controller. Each received byte arrives with a command/data select. Bytes marked as data go straight through to the pixel-write sequencer. Bytes marked as commands are parsed into an opcode and a fixed number of argument bytes. The number of arguments depends on the opcode and ranges from zero to eight.

When the last argument of a command arrives, the decoder fires a one-cycle strobe. There are three strobes: one loads the column window, one loads the row window and one loads the remap setting. Each strobe comes with the argument values it needs. Commands for brightness, timing, power and similar analog settings are consumed with their arguments and have no visible effect. An opcode outside the known set produces a one-cycle error pulse, and the parser is then ready for a fresh opcode.

Top module: `dispctl_cmd_decoder`

## Requirements
- R1: A byte accepted with `in_dc`=1 appears on `pix_byte` with `pix_vld`=1 in the cycle after it is accepted, and it does not advance the command parser.
- R2: Opcode 0x15 followed by two arguments A, B pulses `col_stb` for one cycle, in the cycle after B is accepted, with `win_first`=A and `win_last`=B.
- R3: Opcode 0x75 followed by two arguments A, B pulses `row_stb` for one cycle, in the cycle after B is accepted, with `win_first`=A and `win_last`=B.
- R4: Opcode 0xA0 followed by one argument V pulses `remap_stb` in the cycle after V is accepted, with `remap_val`=V.
- R5: The opcodes 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF each consume exactly one argument byte, of any value, and produce no strobe. The byte after that argument is taken as an opcode.
- R6: The opcodes 0x84, 0x85, 0x86, 0xA4, 0xA5, 0xA6, 0xA7, 0xAE, 0xAF and 0xE3 complete at once with no argument and produce no strobe.
- R7: Opcode 0xB8 consumes exactly eight argument bytes and produces no strobe, even when those bytes have opcode values.
- R8: An opcode byte of 0xFF is dropped with no strobe and no error.
- R9: Any other opcode byte pulses `err_pulse` for exactly one cycle, in the cycle after it is accepted. The next command byte is taken as a new opcode.
- R10: Data bytes that arrive between the bytes of a command do not disturb it. The command resumes with its next argument and completes normally.
- R11: After reset all strobes and `pix_vld` are low and the parser expects an opcode. At most one of `col_stb`, `row_stb`, `remap_stb` and `err_pulse` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | A byte is offered in this cycle |
| in_byte | input | 8 | Received byte |
| in_dc | input | 1 | 1 = pixel data, 0 = command byte |
| pix_vld | output | 1 | Pixel byte valid |
| pix_byte | output | 8 | Pixel byte for the framebuffer sequencer |
| col_stb | output | 1 | Column window load strobe |
| row_stb | output | 1 | Row window load strobe |
| win_first | output | 8 | Window start value, valid with a window strobe |
| win_last | output | 8 | Window end value, valid with a window strobe |
| remap_stb | output | 1 | Remap register load strobe |
| remap_val | output | 8 | Remap value, valid with `remap_stb` |
| err_pulse | output | 1 | Unknown opcode seen |

## Verification
A wrong argument count stored inside the parser stays hidden until the next command. It shows up as a strobe that is missing, late or spurious, or as an error pulse raised on what should have been an argument. Every command byte is therefore checked against a byte-level model in the cycle right after it is accepted. The eight-argument command and interleaved data bytes are where a counter fault shows, and each of these is followed directly by a command whose strobe is visible. A fault in the class table shows one cycle after the opcode as a missing or spurious error pulse.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  localparam int BYTE_W = 8;
  localparam int NEED_W = 4;

  typedef enum logic [2:0] {
    K_COLWIN,
    K_ROWWIN,
    K_REMAP,
    K_DROP,
    K_SKIP,
    K_BAD
  } op_kind_e;

  // Classify an opcode byte.
  function automatic op_kind_e kind_of(input logic [BYTE_W-1:0] op);
    op_kind_e k;
    case (op)
      8'h15: k = K_COLWIN;
      8'h75: k = K_ROWWIN;
      8'hA0: k = K_REMAP;
      8'h81, 8'h84, 8'h85, 8'h86,
      8'hA1, 8'hA2, 8'hA4, 8'hA5, 8'hA6, 8'hA7, 8'hA8,
      8'hAD, 8'hAE, 8'hAF,
      8'hB1, 8'hB2, 8'hB3, 8'hB8, 8'hBC, 8'hBE, 8'hBF,
      8'hE3: k = K_DROP;
      8'hFF: k = K_SKIP;
      default: k = K_BAD;
    endcase
    return k;
  endfunction

  // Argument bytes that follow an opcode.
  function automatic logic [NEED_W-1:0] args_of(input logic [BYTE_W-1:0] op);
    logic [NEED_W-1:0] n;
    case (op)
      8'h15, 8'h75: n = 4'd2;
      8'hA0, 8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
      8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF: n = 4'd1;
      8'hB8: n = 4'd8;
      default: n = 4'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/dcd_router.sv
module dcd_router
  import dcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_dc,
  output logic              cmd_vld_o,
  output logic [BYTE_W-1:0] cmd_byte_o,
  output logic              pix_vld_o,
  output logic [BYTE_W-1:0] pix_byte_o
);

  logic pix_take;

  assign pix_take   = in_vld && in_dc;
  assign cmd_vld_o  = in_vld && !in_dc;
  assign cmd_byte_o = in_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_vld_o  <= 1'b0;
      pix_byte_o <= '0;
    end else begin
      pix_vld_o <= pix_take;
      if (pix_take) pix_byte_o <= in_byte;
    end
  end

  AST_PIX_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_dc) |=> (pix_vld_o && pix_byte_o == $past(in_byte))); // R1
  AST_PIX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_vld && in_dc) |=> !pix_vld_o); // R1

endmodule

// File: rtl/dcd_arg_collect.sv
module dcd_arg_collect
  import dcd_pkg::*;
#(
  parameter int ARG_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [BYTE_W-1:0] cmd_byte,
  output logic              done_o,
  output logic              bad_o,
  output op_kind_e          kind_o,
  output logic [BYTE_W-1:0] arg_first_o,
  output logic [BYTE_W-1:0] arg_last_o,
  output logic              busy_o
);

  localparam int CW = $clog2(ARG_DEPTH + 1);

  logic              busy_q;
  op_kind_e          kind_q;
  logic [CW-1:0]     need_q;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     cnt_inc;
  logic [BYTE_W-1:0] argbuf [ARG_DEPTH];

  op_kind_e          byte_kind;
  logic [CW-1:0]     byte_need;
  logic              take_op;
  logic              take_arg;
  logic              arg_final;

  assign byte_kind = kind_of(cmd_byte);
  assign byte_need = CW'(args_of(cmd_byte));
  assign take_op   = cmd_vld && !busy_q;
  assign take_arg  = cmd_vld && busy_q;
  assign cnt_inc   = cnt_q + 1'b1;
  assign arg_final = take_arg && (cnt_inc == need_q);

  // Completion and error events, brought out for the executor.
  always_comb begin
    done_o      = 1'b0;
    bad_o       = 1'b0;
    kind_o      = K_DROP;
    arg_first_o = argbuf[0];
    arg_last_o  = cmd_byte;
    if (take_op) begin
      if (byte_kind == K_BAD) begin
        bad_o = 1'b1;
      end else if (byte_kind != K_SKIP && byte_need == '0) begin
        done_o = 1'b1;
        kind_o = byte_kind;
      end
    end else if (arg_final) begin
      done_o = 1'b1;
      kind_o = kind_q;
      if (cnt_q == '0) arg_first_o = cmd_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind_q <= K_DROP;
      need_q <= '0;
      cnt_q  <= '0;
    end else if (take_op) begin
      cnt_q <= '0;
      if (byte_kind != K_BAD && byte_kind != K_SKIP && byte_need != '0) begin
        busy_q <= 1'b1;
        kind_q <= byte_kind;
        need_q <= byte_need;
      end
    end else if (take_arg) begin
      if (arg_final) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_inc;
      end
    end
  end

  for (genvar i = 0; i < ARG_DEPTH; i++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rst_n) argbuf[i] <= '0;
      else if (take_arg && cnt_q == CW'(i)) argbuf[i] <= cmd_byte;
    end
  end

  assign busy_o = busy_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < need_q)); // R7
  AST_DATA_HOLDS_PARSE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> ($stable(busy_q) && $stable(cnt_q))); // R10
  AST_NO_ERR_ON_ARG: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !bad_o); // R7

endmodule

// File: rtl/dcd_exec.sv
module dcd_exec
  import dcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic              bad_i,
  input  op_kind_e          kind_i,
  input  logic [BYTE_W-1:0] arg_first_i,
  input  logic [BYTE_W-1:0] arg_last_i,
  output logic              col_stb_o,
  output logic              row_stb_o,
  output logic [BYTE_W-1:0] win_first_o,
  output logic [BYTE_W-1:0] win_last_o,
  output logic              remap_stb_o,
  output logic [BYTE_W-1:0] remap_val_o,
  output logic              err_o
);

  logic fire_col, fire_row, fire_remap;

  assign fire_col   = done_i && kind_i == K_COLWIN;
  assign fire_row   = done_i && kind_i == K_ROWWIN;
  assign fire_remap = done_i && kind_i == K_REMAP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_stb_o   <= 1'b0;
      row_stb_o   <= 1'b0;
      remap_stb_o <= 1'b0;
      err_o       <= 1'b0;
      win_first_o <= '0;
      win_last_o  <= '0;
      remap_val_o <= '0;
    end else begin
      col_stb_o   <= fire_col;
      row_stb_o   <= fire_row;
      remap_stb_o <= fire_remap;
      err_o       <= bad_i;
      if (fire_col || fire_row) begin
        win_first_o <= arg_first_i;
        win_last_o  <= arg_last_i;
      end
      if (fire_remap) remap_val_o <= arg_last_i;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({col_stb_o, row_stb_o, remap_stb_o, err_o})); // R11
  AST_ERR_FROM_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(bad_i)); // R9
  AST_WIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire_col || fire_row) |=> ($stable(win_first_o) && $stable(win_last_o))); // R2

endmodule

// File: rtl/dispctl_cmd_decoder.sv
module dispctl_cmd_decoder
  import dcd_pkg::*;
#(
  parameter int ARG_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_vld,
  input  logic [7:0] in_byte,
  input  logic       in_dc,
  output logic       pix_vld,
  output logic [7:0] pix_byte,
  output logic       col_stb,
  output logic       row_stb,
  output logic [7:0] win_first,
  output logic [7:0] win_last,
  output logic       remap_stb,
  output logic [7:0] remap_val,
  output logic       err_pulse
);

  logic              cmd_vld;
  logic [BYTE_W-1:0] cmd_byte;
  logic              cmd_done;
  logic              cmd_bad;
  op_kind_e          cmd_kind;
  logic [BYTE_W-1:0] cmd_arg_first;
  logic [BYTE_W-1:0] cmd_arg_last;
  logic              parse_busy;

  dcd_router u_router (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld     (in_vld),
    .in_byte    (in_byte),
    .in_dc      (in_dc),
    .cmd_vld_o  (cmd_vld),
    .cmd_byte_o (cmd_byte),
    .pix_vld_o  (pix_vld),
    .pix_byte_o (pix_byte)
  );

  dcd_arg_collect #(.ARG_DEPTH(ARG_DEPTH)) u_collect (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_vld     (cmd_vld),
    .cmd_byte    (cmd_byte),
    .done_o      (cmd_done),
    .bad_o       (cmd_bad),
    .kind_o      (cmd_kind),
    .arg_first_o (cmd_arg_first),
    .arg_last_o  (cmd_arg_last),
    .busy_o      (parse_busy)
  );

  dcd_exec u_exec (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_i      (cmd_done),
    .bad_i       (cmd_bad),
    .kind_i      (cmd_kind),
    .arg_first_i (cmd_arg_first),
    .arg_last_i  (cmd_arg_last),
    .col_stb_o   (col_stb),
    .row_stb_o   (row_stb),
    .win_first_o (win_first),
    .win_last_o  (win_last),
    .remap_stb_o (remap_stb),
    .remap_val_o (remap_val),
    .err_o       (err_pulse)
  );

  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_dc && !parse_busy && in_byte == 8'hFF)
      |=> !(err_pulse || col_stb || row_stb || remap_stb)); // R8
  AST_BAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && !$past(cmd_bad, 2)) |=> (!err_pulse || $past(cmd_bad))); // R9

endmodule

// File: tb/sim_dispctl_cmd_decoder.sv
module sim_dispctl_cmd_decoder;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_vld = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_dc = 1'b0;
  logic       pix_vld, col_stb, row_stb, remap_stb, err_pulse;
  logic [7:0] pix_byte, win_first, win_last, remap_val;

  int checks = 0;
  int fails = 0;
  string cur_req = "R11";

  // reference model state
  bit       m_busy = 0;
  int       m_need = 0;
  int       m_cnt = 0;
  logic [7:0] m_op = 0;
  logic [7:0] m_a0 = 0;

  // expectation for the byte accepted at the last edge
  bit       e_pix, e_col, e_row, e_remap, e_err;
  logic [7:0] e_pbyte, e_first, e_last, e_rval;

  always #(CLK_PERIOD/2) clk = ~clk;

  dispctl_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte), .in_dc(in_dc),
    .pix_vld(pix_vld), .pix_byte(pix_byte), .col_stb(col_stb), .row_stb(row_stb),
    .win_first(win_first), .win_last(win_last), .remap_stb(remap_stb),
    .remap_val(remap_val), .err_pulse(err_pulse)
  );

  // -1: unknown, -2: dropped filler byte, else argument count
  function automatic int bench_need(input logic [7:0] op);
    if (op == 8'hFF) return -2;
    if (op == 8'hB8) return 8;
    if (op == 8'h15 || op == 8'h75) return 2;
    if (op inside {8'hA0, 8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
                   8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF}) return 1;
    if (op inside {8'h84, 8'h85, 8'h86, 8'hE3, 8'hAE, 8'hAF} ||
        (op >= 8'hA4 && op <= 8'hA7)) return 0;
    return -1;
  endfunction

  task automatic compare();
    bit bad;
    string tag;
    tag = cur_req;
    if (e_pix) tag = "R1";
    if (e_col) tag = "R2";
    if (e_row) tag = "R3";
    if (e_remap) tag = "R4";
    if (e_err) tag = "R9";
    bad = ({pix_vld, col_stb, row_stb, remap_stb, err_pulse} !=
           {e_pix, e_col, e_row, e_remap, e_err});
    if (e_pix && pix_byte != e_pbyte) bad = 1;
    if ((e_col || e_row) && {win_first, win_last} != {e_first, e_last}) bad = 1;
    if (e_remap && remap_val != e_rval) bad = 1;
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s: got pix=%0b/%h col=%0b row=%0b win=%h/%h remap=%0b/%h err=%0b; exp pix=%0b/%h col=%0b row=%0b win=%h/%h remap=%0b/%h err=%0b",
        tag, pix_vld, pix_byte, col_stb, row_stb, win_first, win_last, remap_stb,
        remap_val, err_pulse, e_pix, e_pbyte, e_col, e_row, e_first, e_last,
        e_remap, e_rval, e_err);
    end
  endtask

  task automatic step(input bit v, input bit dc, input logic [7:0] b);
    int n;
    @(negedge clk);
    compare();
    in_vld = v; in_dc = dc; in_byte = b;
    {e_pix, e_col, e_row, e_remap, e_err} = '0;
    if (!v) return;
    if (dc) begin
      e_pix = 1; e_pbyte = b;
    end else if (!m_busy) begin
      n = bench_need(b);
      if (n == -1) e_err = 1;
      else if (n > 0) begin
        m_busy = 1; m_op = b; m_need = n; m_cnt = 0;
      end
    end else begin
      if (m_cnt == 0) m_a0 = b;
      m_cnt++;
      if (m_cnt == m_need) begin
        m_busy = 0;
        if (m_op == 8'h15) begin e_col = 1; e_first = m_a0; e_last = b; end
        if (m_op == 8'h75) begin e_row = 1; e_first = m_a0; e_last = b; end
        if (m_op == 8'hA0) begin e_remap = 1; e_rval = b; end
      end
    end
  endtask

  task automatic cmd(input logic [7:0] b);
    step(1, 0, b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got no finish, exp finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] ops [24];
    ops = '{8'h15, 8'h75, 8'hA0, 8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD, 8'hB1,
            8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF, 8'h84, 8'h85, 8'h86, 8'hA4,
            8'hA7, 8'hAE, 8'hAF, 8'hE3, 8'hB8, 8'hFF};
    void'($urandom(32'd2024));
    {e_pix, e_col, e_row, e_remap, e_err} = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    checks++;
    if ({pix_vld, col_stb, row_stb, remap_stb, err_pulse} != 5'b0) begin
      fails++;
      $display("FAIL R11: got %b exp 00000", {pix_vld, col_stb, row_stb, remap_stb, err_pulse});
    end
    rst_n = 1'b1;
    step(0, 0, 0);

    cur_req = "R2"; cmd(8'h15); cmd(8'h03); cmd(8'h3C); step(0, 0, 0);
    cur_req = "R3"; cmd(8'h75); cmd(8'h00); cmd(8'h4F);
    cur_req = "R4"; cmd(8'hA0); cmd(8'h52);
    cur_req = "R1"; step(1, 1, 8'hC7); step(1, 1, 8'h15);
    cur_req = "R5"; cmd(8'h81); cmd(8'h15); cmd(8'h75); cmd(8'h11); cmd(8'h22);
    cur_req = "R5"; cmd(8'hBF); cmd(8'hEE); cmd(8'hA0); cmd(8'h07);
    cur_req = "R6"; cmd(8'hE3); cmd(8'hA5); cmd(8'hAF); cmd(8'h15); cmd(8'h01); cmd(8'h02);
    cur_req = "R7"; cmd(8'hB8);
    for (int i = 0; i < 8; i++) cmd(i[0] ? 8'h15 : 8'h75);
    cmd(8'hA0); cmd(8'h99);
    cur_req = "R8"; cmd(8'hFF); cmd(8'hFF); cmd(8'hA0); cmd(8'h3A);
    cur_req = "R9"; cmd(8'h00); cmd(8'h15); cmd(8'h05); cmd(8'h06);
    cur_req = "R9"; cmd(8'h42); cmd(8'h43); step(0, 0, 0);
    cur_req = "R10"; cmd(8'h15); cmd(8'h10); step(1, 1, 8'hAB); step(0, 0, 0);
    step(1, 1, 8'hCD); cmd(8'h20);
    cur_req = "R10"; cmd(8'hB8); cmd(8'h01); step(1, 1, 8'h77);
    for (int i = 0; i < 7; i++) cmd(8'hA0);
    cmd(8'h75); cmd(8'h08); cmd(8'h09);

    cur_req = "R11";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 10) step(0, 0, 0);
      else if (r < 30) step(1, 1, 8'($urandom));
      else if (r < 75) cmd(ops[$urandom_range(0, 23)]);
      else cmd(8'($urandom));
    end
    step(0, 0, 0);
    step(0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule